// File: doc/BRIEF.md
# Pointer-Windowed Data Memory Port

This block sits between the execution core of a small 8-bit controller and its data memory. Each cycle the core presents one address with read and write strobes. The block works out which storage that address reaches and returns the read data. Most addresses reach storage directly. Two addresses have no storage of their own. Each acts as a window, and an access through it lands on the location held in a memory pointer register. Window 0 uses pointer 0 and window 1 uses pointer 1. The pointers themselves are ordinary locations, so the core loads them with plain writes.

The block holds both pointer registers, the accumulator and a banked RAM model. The accumulator also has its own output for the core's datapath. If a pointer holds the address of one of the two windows, the access refers back to a window. A read of that kind returns zero, and a write of that kind changes nothing. A window cannot read another window in the same access, so a copy from one memory location to another is done in two steps through the accumulator.

Top module: `dmem_port`

## Requirements
- R1: Address 01h reads and writes pointer 0 and address 03h reads and writes pointer 1. The pointer registers are ADDR_W (8) bits wide.
- R2: An access to address 00h uses pointer 0 as the effective address, and an access to address 02h uses pointer 1. Reads and writes both take this path.
- R3: If a window access has an effective address of 00h or 02h, the read returns 00h.
- R4: If a window access has an effective address of 00h or 02h, the write leaves pointer 0, pointer 1, the accumulator and the RAM unchanged.
- R5: The accumulator sits at address 05h and can be read and written either directly or through a window. Its value is always present on `acc_o`.
- R6: Window accesses always reach bank 0, whatever `bank_sel` holds. Direct accesses below SHARED_LIMIT (40h) also reach bank 0. Direct accesses at or above SHARED_LIMIT reach the bank named by `bank_sel`.
- R7: Read data is combinational in the same cycle. A write takes effect on the rising clock edge only while `wr_en` is 1, and nothing changes while `wr_en` is 0.
- R8: A synchronous active-high reset clears pointer 0, pointer 1 and the accumulator to 00h.
- R9: `rd_data` is 00h whenever `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Data memory address from the core |
| bank_sel | input | BANK_W | Bank used by direct accesses above the shared region |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, combinational |
| acc_o | output | DATA_W | Current accumulator value |

## Verification
A wrong pointer value shows up at the ports on the first window access after the pointer is loaded. The read of 00h or 02h returns data from the wrong location in that same cycle. A direct read of 01h or 03h shows the bad pointer value at once. A faulty self-reference guard can show up in two ways. The window read returns nonzero data in the same cycle. Or a discarded write reaches the accumulator and appears on `acc_o` one edge later. A bank-selection fault shows up only when a later read finds a value in the wrong bank, so the bench stores different data in both banks at one address and reads each bank back.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

   // Fixed locations: the decode and the core both depend on these.
   localparam int WIN0_LOC = 'h00;
   localparam int PTR0_LOC = 'h01;
   localparam int WIN1_LOC = 'h02;
   localparam int PTR1_LOC = 'h03;
   localparam int ACC_LOC  = 'h05;

   typedef enum logic [2:0] {
      TGT_NONE = 3'd0,
      TGT_PTR0 = 3'd1,
      TGT_PTR1 = 3'd2,
      TGT_ACC  = 3'd3,
      TGT_RAM  = 3'd4
   } dmem_tgt_e;

endpackage

// File: rtl/dmem_addr_decode.sv
module dmem_addr_decode
   import dmem_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int NUM_BANKS    = 2,
   parameter int BANK_W       = 1,
   parameter int SHARED_LIMIT = 'h40
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] ptr0,
   input  logic [ADDR_W-1:0] ptr1,
   input  logic [BANK_W-1:0] bank_sel,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [BANK_W-1:0] eff_bank,
   output dmem_tgt_e         target
);

   localparam logic [ADDR_W-1:0] L_WIN0 = ADDR_W'(WIN0_LOC);
   localparam logic [ADDR_W-1:0] L_WIN1 = ADDR_W'(WIN1_LOC);
   localparam logic [ADDR_W-1:0] L_PTR0 = ADDR_W'(PTR0_LOC);
   localparam logic [ADDR_W-1:0] L_PTR1 = ADDR_W'(PTR1_LOC);
   localparam logic [ADDR_W-1:0] L_ACC  = ADDR_W'(ACC_LOC);
   localparam logic [ADDR_W-1:0] L_LIM  = ADDR_W'(SHARED_LIMIT);

   logic via_window;

   // Window redirection through the pointer registers
   always_comb begin
      via_window = 1'b0;
      eff_addr   = addr;
      if (addr == L_WIN0) begin
         via_window = 1'b1;
         eff_addr   = ptr0;
      end else if (addr == L_WIN1) begin
         via_window = 1'b1;
         eff_addr   = ptr1;
      end
   end

   // Target selection; a window landing on a window reaches nothing
   always_comb begin
      if (eff_addr == L_WIN0 || eff_addr == L_WIN1) target = TGT_NONE;
      else if (eff_addr == L_PTR0)                  target = TGT_PTR0;
      else if (eff_addr == L_PTR1)                  target = TGT_PTR1;
      else if (eff_addr == L_ACC)                   target = TGT_ACC;
      else                                          target = TGT_RAM;
   end

   // Bank rule: windows and the shared low region stay in bank 0
   generate
      if (NUM_BANKS == 1) begin : g_single_bank
         assign eff_bank = '0;
      end else begin : g_multi_bank
         always_comb begin
            if (via_window || eff_addr < L_LIM) eff_bank = '0;
            else                                eff_bank = bank_sel;
         end
      end
   endgenerate

endmodule

// File: rtl/dmem_core_regs.sv
module dmem_core_regs
   import dmem_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  dmem_tgt_e         target,
   input  logic [DATA_W-1:0] wr_data,
   output logic [ADDR_W-1:0] ptr0_q,
   output logic [ADDR_W-1:0] ptr1_q,
   output logic [DATA_W-1:0] acc_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr0_q <= '0;
         ptr1_q <= '0;
         acc_q  <= '0;
      end else if (wr_en) begin
         case (target)
            TGT_PTR0: ptr0_q <= wr_data[ADDR_W-1:0];
            TGT_PTR1: ptr1_q <= wr_data[ADDR_W-1:0];
            TGT_ACC:  acc_q  <= wr_data;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/dmem_ram_banks.sv
module dmem_ram_banks #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int NUM_BANKS = 2,
   parameter int BANK_W    = 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] bank,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (NUM_BANKS == 1) begin : g_flat
         logic [DATA_W-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (wr_en) mem[addr] <= wr_data;
         end
         assign rd_data = mem[addr];
      end else begin : g_banked
         logic [DATA_W-1:0] bank_rd [NUM_BANKS];
         for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic [DATA_W-1:0] mem [DEPTH];
            always_ff @(posedge clk) begin
               if (wr_en && bank == BANK_W'(b)) mem[addr] <= wr_data;
            end
            assign bank_rd[b] = mem[addr];
         end
         always_comb begin
            rd_data = '0;
            for (int i = 0; i < NUM_BANKS; i++) begin
               if (bank == BANK_W'(i)) rd_data = bank_rd[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dmem_port.sv
module dmem_port
   import dmem_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter int NUM_BANKS    = 2,
   parameter int SHARED_LIMIT = 'h40,
   parameter int BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] acc_o
);

   // Elaboration-time parameter checks
   generate
      if (ADDR_W < 3) begin : g_err_addr
         $error("dmem_port: ADDR_W must reach the accumulator location");
      end
      if (DATA_W < ADDR_W) begin : g_err_data
         $error("dmem_port: DATA_W must hold a full pointer");
      end
      if (NUM_BANKS < 1) begin : g_err_banks
         $error("dmem_port: NUM_BANKS must be at least 1");
      end
      if (SHARED_LIMIT > (1 << ADDR_W)) begin : g_err_limit
         $error("dmem_port: SHARED_LIMIT exceeds the address space");
      end
   endgenerate

   logic [ADDR_W-1:0] mp0_w;
   logic [ADDR_W-1:0] mp1_w;
   logic [ADDR_W-1:0] eff_addr;
   logic [BANK_W-1:0] eff_bank;
   dmem_tgt_e         target;
   logic [DATA_W-1:0] ram_rd;
   logic              ram_we;

   dmem_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS),
      .BANK_W(BANK_W), .SHARED_LIMIT(SHARED_LIMIT)
   ) u_decode (
      .addr(addr), .ptr0(mp0_w), .ptr1(mp1_w), .bank_sel(bank_sel),
      .eff_addr(eff_addr), .eff_bank(eff_bank), .target(target)
   );

   dmem_core_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .target(target),
      .wr_data(wr_data), .ptr0_q(mp0_w), .ptr1_q(mp1_w), .acc_q(acc_o)
   );

   assign ram_we = wr_en && (target == TGT_RAM);

   dmem_ram_banks #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
   ) u_ram (
      .clk(clk), .wr_en(ram_we), .bank(eff_bank), .addr(eff_addr),
      .wr_data(wr_data), .rd_data(ram_rd)
   );

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         case (target)
            TGT_PTR0: rd_data = DATA_W'(mp0_w);
            TGT_PTR1: rd_data = DATA_W'(mp1_w);
            TGT_ACC:  rd_data = acc_o;
            TGT_RAM:  rd_data = ram_rd;
            default:  rd_data = '0;
         endcase
      end
   end

endmodule

// File: rtl/dmem_port_chk.sv
module dmem_port_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] addr,
   input logic              rd_en,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic [DATA_W-1:0] acc_o,
   input logic [ADDR_W-1:0] mp0,
   input logic [ADDR_W-1:0] mp1
);

   localparam logic [ADDR_W-1:0] C_W0  = ADDR_W'(dmem_pkg::WIN0_LOC);
   localparam logic [ADDR_W-1:0] C_W1  = ADDR_W'(dmem_pkg::WIN1_LOC);
   localparam logic [ADDR_W-1:0] C_P0  = ADDR_W'(dmem_pkg::PTR0_LOC);
   localparam logic [ADDR_W-1:0] C_ACC = ADDR_W'(dmem_pkg::ACC_LOC);

   logic rst_d = 1'b0;
   always_ff @(posedge clk) rst_d <= rst;

   logic self_ref;
   assign self_ref = (addr == C_W0 && (mp0 == C_W0 || mp0 == C_W1)) ||
                     (addr == C_W1 && (mp1 == C_W0 || mp1 == C_W1));

   assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
      rst_d |-> (mp0 == '0 && mp1 == '0 && acc_o == '0));

   assert_ptr0_load_R1: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == C_P0) |=> mp0 == $past(wr_data[ADDR_W-1:0]));

   assert_selfref_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (rd_en && self_ref) |-> rd_data == '0);

   assert_selfref_write_dropped_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && self_ref) |=> ($stable(mp0) && $stable(mp1) && $stable(acc_o)));

   assert_acc_readback_R5: assert property (@(posedge clk) disable iff (rst)
      (rd_en && addr == C_ACC) |-> rd_data == acc_o);

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> ($stable(mp0) && $stable(mp1) && $stable(acc_o)));

   assert_no_read_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      !rd_en |-> rd_data == '0);

endmodule

bind dmem_port dmem_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
   .wr_data(wr_data), .rd_data(rd_data), .acc_o(acc_o),
   .mp0(mp0_w), .mp1(mp1_w)
);

// File: tb/dmem_port_tb.sv
module dmem_port_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] addr = '0;
   logic [0:0] bank_sel = '0;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [7:0] acc_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dmem_port u_dut (
      .clk(clk), .rst(rst), .addr(addr), .bank_sel(bank_sel),
      .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .acc_o(acc_o)
   );

   // {write, addr, bank, data-or-expected, requirement}
   localparam int NV = 35;
   localparam logic [21:0] VEC [NV] = '{
      {1'b1, 8'h05, 1'b0, 8'h3C, 4'd5},  // R5 load accumulator
      {1'b0, 8'h05, 1'b0, 8'h3C, 4'd5},
      {1'b1, 8'h01, 1'b0, 8'h50, 4'd1},  // R1 pointer 0 = 50h
      {1'b0, 8'h01, 1'b0, 8'h50, 4'd1},
      {1'b1, 8'h00, 1'b0, 8'hA7, 4'd2},  // R2 write through window 0
      {1'b0, 8'h50, 1'b0, 8'hA7, 4'd2},
      {1'b1, 8'h50, 1'b1, 8'h11, 4'd6},  // R6 bank 1 copy of 50h
      {1'b0, 8'h50, 1'b1, 8'h11, 4'd6},
      {1'b0, 8'h00, 1'b1, 8'hA7, 4'd6},  // R6 window ignores bank_sel
      {1'b1, 8'h03, 1'b0, 8'h50, 4'd1},
      {1'b0, 8'h03, 1'b0, 8'h50, 4'd1},
      {1'b0, 8'h02, 1'b1, 8'hA7, 4'd2},  // R2 read through window 1
      {1'b1, 8'h02, 1'b1, 8'h99, 4'd6},
      {1'b0, 8'h50, 1'b0, 8'h99, 4'd6},
      {1'b0, 8'h50, 1'b1, 8'h11, 4'd6},
      {1'b1, 8'h20, 1'b1, 8'h77, 4'd6},  // R6 shared region
      {1'b0, 8'h20, 1'b0, 8'h77, 4'd6},
      {1'b1, 8'h01, 1'b0, 8'h02, 4'd1},  // pointer 0 -> window 1
      {1'b0, 8'h00, 1'b0, 8'h00, 4'd3},  // R3
      {1'b1, 8'h03, 1'b0, 8'h00, 4'd1},  // pointer 1 -> window 0
      {1'b0, 8'h02, 1'b0, 8'h00, 4'd3},  // R3
      {1'b1, 8'h00, 1'b0, 8'h5A, 4'd4},  // R4 dropped write
      {1'b0, 8'h01, 1'b0, 8'h02, 4'd4},
      {1'b0, 8'h03, 1'b0, 8'h00, 4'd4},
      {1'b0, 8'h05, 1'b0, 8'h3C, 4'd4},
      {1'b1, 8'h02, 1'b0, 8'h6B, 4'd4},  // R4 dropped write
      {1'b0, 8'h01, 1'b0, 8'h02, 4'd4},
      {1'b0, 8'h03, 1'b0, 8'h00, 4'd4},
      {1'b0, 8'h05, 1'b0, 8'h3C, 4'd4},
      {1'b1, 8'h01, 1'b0, 8'h05, 4'd5},  // window 0 onto accumulator
      {1'b1, 8'h00, 1'b0, 8'hE1, 4'd5},
      {1'b0, 8'h05, 1'b0, 8'hE1, 4'd5},
      {1'b1, 8'h01, 1'b0, 8'h01, 4'd1},  // window 0 onto pointer 0
      {1'b1, 8'h00, 1'b0, 8'h33, 4'd1},
      {1'b0, 8'h01, 1'b0, 8'h33, 4'd1}
   };

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL R%0d: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic wr, input logic [7:0] a, input logic b,
                        input logic [7:0] d, input int req);
      @(negedge clk);
      addr = a; bank_sel = b; wr_data = d; wr_en = wr; rd_en = !wr;
      #2;
      if (!wr) check(rd_data, d, req);
      @(posedge clk);
      #1;
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog expired, R1 to R9 incomplete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R8 reset state
      #2 check(acc_o, 8'h00, 8);
      apply(1'b0, 8'h01, 1'b0, 8'h00, 8);
      apply(1'b0, 8'h03, 1'b0, 8'h00, 8);
      apply(1'b0, 8'h05, 1'b0, 8'h00, 8);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][21], VEC[i][20:13], VEC[i][12], VEC[i][11:4], int'(VEC[i][3:0]));
      end
      check(acc_o, 8'hE1, 5);   // R5 acc_o tracks the accumulator

      // R9: read strobe low keeps rd_data at zero
      @(negedge clk);
      addr = 8'h05; rd_en = 1'b0; wr_en = 1'b0;
      #2 check(rd_data, 8'h00, 9);

      // R7: data with wr_en low is ignored
      wr_data = 8'hFF;
      @(posedge clk);
      #1 check(acc_o, 8'hE1, 7);

      // R7: a write lands at the edge, not before
      @(negedge clk);
      addr = 8'h05; wr_data = 8'h42; wr_en = 1'b1;
      #2 check(acc_o, 8'hE1, 7);
      @(posedge clk);
      #1 check(acc_o, 8'h42, 7);
      wr_en = 1'b0;

      // R8: reset in mid-run clears the registers
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #2 check(acc_o, 8'h00, 8);
      apply(1'b0, 8'h01, 1'b0, 8'h00, 8);
      apply(1'b0, 8'h03, 1'b0, 8'h00, 8);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule